// File: doc/BRIEF.md
# Pulse-Swallow Dual-Modulus Frequency Divider

This block divides its clock by a programmable ratio with the pulse-swallow method. A prescaler model divides by either P or P+1, where P is 64 or 128. A swallow count A and a program count B decide how many prescaler cycles use each modulus. The first A prescaler cycles of every output period use the wide modulus P+1. The remaining B−A cycles use P. The period is therefore N = P·B + A input clocks. At the last clock of each period the block raises a single-clock output pulse, and all counting restarts.

Software writes a new setting by presenting A, B and the modulus-pair select with a one-clock load strobe. The setting is checked and then held as pending. It replaces the running setting only at the next period boundary, so a period that is in progress always finishes with the ratio it started with. A setting is rejected if B is smaller than A or if B is below 3. In that case an error flag rises and nothing changes.

Top module: `pswallow_divider`

## Requirements
- R1: With the pair select at 0 (P = 64), consecutive output pulses are exactly 64·B + A clocks apart. Each prescaler cycle lasts 65 clocks while fewer than A prescaler cycles of the current period have completed, and 64 clocks after that.
- R2: With the pair select at 1 (P = 128), the spacing is exactly 128·B + A clocks, using prescaler cycles of 129 and then 128 clocks.
- R3: `div_pulse` is high for exactly one clock, the last clock of each period. The first pulse after reset release comes on the N-th clock edge after release.
- R4: During reset and right after it, `div_pulse` and `cfg_err` are low. The running setting after reset is A = 0, B = 3, select 0, which gives a 192-clock period.
- R5: A load accepted during a period does not change that period. The new ratio governs every period from the next boundary on. A load whose strobe falls on the last clock of a period waits for the boundary after that one.
- R6: A load with B < A is rejected. `cfg_err` is high one clock after the strobe, and the pulse spacing stays as before.
- R7: A load with B < 3 is rejected in the same way as in R6.
- R8: `cfg_err` keeps its value until the next load. An accepted load clears it one clock after the strobe.
- R9: When several loads occur in one period, the last accepted one is applied at the boundary. A rejected load does not discard an earlier accepted pending setting.
- R10: A = 0 gives a period made only of P-clock prescaler cycles, and A = B gives a period made only of (P+1)-clock cycles. The limits A = 127 and B = 127 with P = 128 give a period of 16383 clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock being divided |
| rst_n | input | 1 | Asynchronous active-low reset |
| load | input | 1 | One-clock strobe that captures a_in, b_in and pair_hi |
| a_in | input | 7 | Swallow count A (0..127) |
| b_in | input | 11 | Program count B (3..2047, B ≥ A) |
| pair_hi | input | 1 | Modulus pair: 0 selects 64/65, 1 selects 128/129 |
| div_pulse | output | 1 | One-clock pulse on the last clock of each period |
| cfg_err | output | 1 | Last load was rejected |

## Verification
`cfg_err` is registered, so the bench reads it at the falling edge that follows the clock edge which took the strobe. It compares the flag there with the value the requirement predicts. `div_pulse` is decoded from registered counter state and is valid for the whole last clock of a period. A monitor counts falling edges since reset release, and since each pulse. It compares every gap with the next period length that the driver queued. For each load, the driver first queues the old length, because that period is already running, and then queues the new length. A boundary that comes early or late by even one clock therefore shows up as a mismatch at the pulse concerned.

// File: rtl/psd_pkg.sv
package psd_pkg;

  typedef enum logic {PAIR_LO = 1'b0, PAIR_HI = 1'b1} pair_e;

  // A setting is usable when the program count is large enough and
  // covers the swallow count.
  function automatic bit cfg_ok(input int a, input int b, input int b_min);
    return (b >= b_min) && (b >= a);
  endfunction

  // Length in clocks of one prescaler cycle.
  function automatic int ps_modulus(input bit hi, input bit wide,
                                    input int p_lo, input int p_hi);
    return (hi ? p_hi : p_lo) + (wide ? 1 : 0);
  endfunction

  // Whole output period in clocks.
  function automatic int period_len(input bit hi, input int a, input int b,
                                    input int p_lo, input int p_hi);
    return (hi ? p_hi : p_lo) * b + a;
  endfunction

endpackage

// File: rtl/psd_cfg_regs.sv
module psd_cfg_regs #(
  parameter int A_W   = 7,
  parameter int B_W   = 11,
  parameter int B_MIN = 3,
  parameter int RST_A = 0,
  parameter int RST_B = 3
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           load,
  input  logic [A_W-1:0] a_in,
  input  logic [B_W-1:0] b_in,
  input  logic           hi_in,
  input  logic           period_end,
  output logic [A_W-1:0] act_a,
  output logic [B_W-1:0] act_b,
  output logic           act_hi,
  output logic           cfg_err
);
  import psd_pkg::*;

  logic [A_W-1:0] pend_a;
  logic [B_W-1:0] pend_b;
  logic           pend_hi;
  logic           pend_v;
  logic           in_ok;

  assign in_ok = cfg_ok(int'(a_in), int'(b_in), B_MIN);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_a  <= A_W'(RST_A);
      pend_b  <= B_W'(RST_B);
      pend_hi <= PAIR_LO;
      pend_v  <= 1'b0;
      act_a   <= A_W'(RST_A);
      act_b   <= B_W'(RST_B);
      act_hi  <= PAIR_LO;
      cfg_err <= 1'b0;
    end else begin
      // boundary transfer first, so a same-cycle accepted load stays pending
      if (period_end && pend_v) begin
        act_a  <= pend_a;
        act_b  <= pend_b;
        act_hi <= pend_hi;
        pend_v <= 1'b0;
      end
      if (load) begin
        cfg_err <= ~in_ok;
        if (in_ok) begin
          pend_a  <= a_in;
          pend_b  <= b_in;
          pend_hi <= hi_in;
          pend_v  <= 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/psd_prescaler.sv
module psd_prescaler #(
  parameter int P_LO = 64,
  parameter int P_HI = 128,
  localparam int PC_W = $clog2(P_HI + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic hi,
  input  logic wide,
  output logic ps_end
);
  import psd_pkg::*;

  logic [PC_W-1:0] pc;
  logic [PC_W-1:0] last_cnt;

  assign last_cnt = PC_W'(ps_modulus(hi, wide, P_LO, P_HI) - 1);
  assign ps_end   = (pc == last_cnt);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      pc <= '0;
    else if (ps_end) pc <= '0;
    else             pc <= pc + 1'b1;
  end

endmodule

// File: rtl/psd_swallow_ctrl.sv
module psd_swallow_ctrl #(
  parameter int A_W = 7,
  parameter int B_W = 11
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           ps_end,
  input  logic [A_W-1:0] act_a,
  input  logic [B_W-1:0] act_b,
  output logic           wide,
  output logic           period_end
);
  // prescaler cycles completed in the current output period
  logic [B_W-1:0] tick;

  assign wide       = tick < {{(B_W-A_W){1'b0}}, act_a};
  assign period_end = ps_end && (tick == act_b - 1'b1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          tick <= '0;
    else if (period_end) tick <= '0;
    else if (ps_end)     tick <= tick + 1'b1;
  end

endmodule

// File: rtl/pswallow_divider.sv
module pswallow_divider #(
  parameter int A_W   = 7,
  parameter int B_W   = 11,
  parameter int P_LO  = 64,
  parameter int P_HI  = 128,
  parameter int B_MIN = 3,
  parameter int RST_A = 0,
  parameter int RST_B = 3
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           load,
  input  logic [A_W-1:0] a_in,
  input  logic [B_W-1:0] b_in,
  input  logic           pair_hi,
  output logic           div_pulse,
  output logic           cfg_err
);
  // named internal events, visible to the bound checker
  logic           ps_end;
  logic           wide;
  logic           period_end;
  logic [A_W-1:0] act_a;
  logic [B_W-1:0] act_b;
  logic           act_hi;

  psd_cfg_regs #(
    .A_W(A_W), .B_W(B_W), .B_MIN(B_MIN), .RST_A(RST_A), .RST_B(RST_B)
  ) cfg_i (
    .clk(clk), .rst_n(rst_n), .load(load), .a_in(a_in), .b_in(b_in),
    .hi_in(pair_hi), .period_end(period_end),
    .act_a(act_a), .act_b(act_b), .act_hi(act_hi), .cfg_err(cfg_err)
  );

  psd_prescaler #(.P_LO(P_LO), .P_HI(P_HI)) pre_i (
    .clk(clk), .rst_n(rst_n), .hi(act_hi), .wide(wide), .ps_end(ps_end)
  );

  psd_swallow_ctrl #(.A_W(A_W), .B_W(B_W)) swc_i (
    .clk(clk), .rst_n(rst_n), .ps_end(ps_end), .act_a(act_a), .act_b(act_b),
    .wide(wide), .period_end(period_end)
  );

  assign div_pulse = period_end;

endmodule

// File: rtl/psd_checker.sv
module psd_checker #(
  parameter int A_W   = 7,
  parameter int B_W   = 11,
  parameter int P_LO  = 64,
  parameter int P_HI  = 128,
  parameter int B_MIN = 3
) (
  input logic           clk,
  input logic           rst_n,
  input logic           load,
  input logic [A_W-1:0] a_in,
  input logic [B_W-1:0] b_in,
  input logic           div_pulse,
  input logic           cfg_err,
  input logic           ps_end,
  input logic           wide,
  input logic           period_end,
  input logic [A_W-1:0] act_a,
  input logic [B_W-1:0] act_b,
  input logic           act_hi
);
  import psd_pkg::*;

  logic [15:0] len;
  logic        in_ok;

  assign in_ok = cfg_ok(int'(a_in), int'(b_in), B_MIN);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      len <= 16'd1;
    else if (ps_end) len <= 16'd1;
    else             len <= len + 16'd1;
  end

  // R1 and R2: observed prescaler cycle length matches the modulus in force
  assert_ps_len_R1: assert property (@(posedge clk) disable iff (!rst_n)
    ps_end |-> (int'(len) == ps_modulus(act_hi, wide, P_LO, P_HI)));

  assert_pulse_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
    div_pulse |=> !div_pulse);

  assert_pulse_on_ps_R3: assert property (@(posedge clk) disable iff (!rst_n)
    div_pulse |-> ps_end);

  assert_hold_cfg_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !period_end |=> ($stable(act_a) && $stable(act_b) && $stable(act_hi)));

  assert_bad_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (load && !in_ok) |=> cfg_err);

  assert_active_legal_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(act_b) >= B_MIN) && (act_b >= B_W'(act_a)));

  assert_clear_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (load && in_ok) |=> !cfg_err);

  assert_err_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(cfg_err));

endmodule

bind pswallow_divider psd_checker #(
  .A_W(A_W), .B_W(B_W), .P_LO(P_LO), .P_HI(P_HI), .B_MIN(B_MIN)
) chk_i (
  .clk(clk), .rst_n(rst_n), .load(load), .a_in(a_in), .b_in(b_in),
  .div_pulse(div_pulse), .cfg_err(cfg_err), .ps_end(ps_end), .wide(wide),
  .period_end(period_end), .act_a(act_a), .act_b(act_b), .act_hi(act_hi)
);

// File: tb/pswallow_divider_tb_top.sv
`timescale 1ns/1ps
module pswallow_divider_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        load = 1'b0;
  logic [6:0]  a_in = '0;
  logic [10:0] b_in = '0;
  logic        pair_hi = 1'b0;
  logic        div_pulse;
  logic        cfg_err;

  int n_cmp = 0;
  int n_bad = 0;
  int seen  = 0;
  int gap   = 1;
  int cur_n = 192;
  bit done  = 1'b0;
  int exp_q[$];

  always #5 clk = ~clk;

  pswallow_divider dut_i (
    .clk(clk), .rst_n(rst_n), .load(load), .a_in(a_in), .b_in(b_in),
    .pair_hi(pair_hi), .div_pulse(div_pulse), .cfg_err(cfg_err)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int plen(input bit hi, input int a, input int b);
    return (hi ? 128 : 64) * b + a;
  endfunction

  // monitor: measure each pulse gap and compare with the queued expectation
  always @(negedge clk) begin
    if (!rst_n) begin
      gap = 1;
    end else begin
      gap = gap + 1;
      if (div_pulse) begin
        if (exp_q.size() == 0) begin
          chk(1'b0, "R3 unexpected pulse", gap, 0);
        end else begin
          int e;
          e = exp_q.pop_front();
          chk(gap == e, "R1/R2/R5 pulse spacing", gap, e);
        end
        gap = 0;
        seen = seen + 1;
      end
    end
  end

  task automatic do_load(input bit hi, input int a, input int b, input bit exp_err,
                         input string req);
    @(negedge clk);
    pair_hi = hi; a_in = 7'(a); b_in = 11'(b); load = 1'b1;
    @(negedge clk);
    load = 1'b0;
    chk(cfg_err == exp_err, req, int'(cfg_err), int'(exp_err));
  endtask

  // called right after a pulse; the running period still uses cur_n
  task automatic finish_step(input int new_n, input int nper);
    int base;
    base = seen;
    for (int i = 0; i < nper; i++) exp_q.push_back(new_n);
    wait (seen == base + 1 + nper);
    cur_n = new_n;
  endtask

  task automatic step(input bit hi, input int a, input int b, input bit exp_err,
                      input string req, input int nper);
    int nn;
    exp_q.push_back(cur_n);
    repeat (5) @(negedge clk);
    do_load(hi, a, b, exp_err, req);
    nn = exp_err ? cur_n : plen(hi, a, b);
    finish_step(nn, nper);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    chk(div_pulse == 1'b0, "R4 pulse low in reset", int'(div_pulse), 0);
    chk(cfg_err == 1'b0, "R4 error low in reset", int'(cfg_err), 0);
    #1 rst_n = 1'b1;
    @(negedge clk);
    chk(div_pulse == 1'b0 && cfg_err == 1'b0, "R4 outputs low after release",
        int'(div_pulse) + int'(cfg_err), 0);
    // R4 and R3: default 192-clock period, first pulse on the 192nd edge
    exp_q.push_back(192);
    wait (seen == 1);

    step(1'b0, 2, 5, 1'b0, "R1 load accepted", 2);          // 322
    step(1'b0, 4, 4, 1'b0, "R10 A equals B accepted", 2);   // 260
    step(1'b0, 5, 4, 1'b1, "R6 B below A rejected", 2);     // stays 260
    step(1'b0, 0, 2, 1'b1, "R7 B below 3 rejected", 2);     // stays 260
    step(1'b1, 1, 3, 1'b0, "R8 accepted load clears error", 2); // 385
    step(1'b1, 127, 127, 1'b0, "R10 limits accepted", 2);   // 16383
    step(1'b0, 0, 130, 1'b0, "R10 A zero accepted", 2);     // 8320

    // R9: two accepted loads in one period, last wins
    exp_q.push_back(cur_n);
    repeat (5) @(negedge clk);
    do_load(1'b0, 3, 10, 1'b0, "R9 first load accepted");
    do_load(1'b0, 1, 6, 1'b0, "R9 second load accepted");
    finish_step(plen(1'b0, 1, 6), 2);                       // 385

    // R9: accepted then rejected, accepted one still applies
    exp_q.push_back(cur_n);
    repeat (5) @(negedge clk);
    do_load(1'b0, 0, 7, 1'b0, "R9 pending load accepted");
    do_load(1'b1, 9, 8, 1'b1, "R9 later bad load flagged");
    finish_step(plen(1'b0, 0, 7), 2);                       // 448
    chk(cfg_err == 1'b1, "R8 error held without load", int'(cfg_err), 1);

    chk(exp_q.size() == 0, "R3 all expected pulses seen", exp_q.size(), 0);
    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual %0d expected %0d", seen, seen + 1);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule